// File: doc/BRIEF.md
# Low-Latency DRAM Power-Up Sequencer

This block sits on the controller side of a multi-bank low-latency DRAM. It generates the start-up command stream that the memory needs before it can accept normal traffic. After reset it keeps the command bus idle (NOP) for a stabilization interval. It then writes the mode register three times: two dummy writes with an all-zero address, then one real write that carries the caller's mode word. Finally it refreshes every bank once, in ascending bank order. When that is finished it raises a sticky done flag and hands the bus to the normal request path.

All intervals are given as clock-cycle counts on input pins. The caller converts the microsecond and nanosecond figures for its own clock frequency: the stabilization wait, the spacing between mode-register writes, the row-cycle spacing between refreshes, and the relock wait. A value of zero behaves as one.

After start-up the block also handles a stopped clock. A one-cycle restart pulse opens a relock window. While that window is open, READ requests are turned into NOP. Every other request still passes through.

Top module: `lldram_init_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, the bus drives command NOP, bank 0 and address 0, and done is low. Command codes are NOP=0, MRS=1, REFRESH=2, READ=3, WRITE=4.
- R2: Counting the clock edges after reset is released, the first MRS appears after edge max(stab,1). Every bus cycle before it is NOP.
- R3: Exactly three MRS commands are issued. Each one follows the previous one by max(mrsc,1) edges, and the bus carries NOP between them.
- R4: The first two MRS commands drive address 0. The third drives the mode word with address bits 17 down to 10 forced to zero. All three drive bank 0.
- R5: The first REFRESH follows the last MRS by max(mrsc,1) edges. Then one REFRESH goes to each of banks 0 to 7, in ascending order, with max(rc,1) edges between them. Each REFRESH drives address 0, and the bus carries NOP between them.
- R6: Done rises max(rc,1) edges after the eighth REFRESH. Once high, it stays high until reset, including through any relock window.
- R7: While done is low, requests are ignored. The bus carries only the start-up schedule.
- R8: While done is high, a request presented in one cycle appears on the bus after the next edge with its command, bank and address unchanged. A cycle with no request gives NOP.
- R9: A restart pulse while done is high blocks READ requests: both the one presented in the pulse cycle and those presented in the following max(relock,1) cycles leave NOP on the bus. Non-READ requests pass through during the window, and READ passes again after it.
- R10: A restart pulse during an open relock window restarts the full max(relock,1) wait from that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stab_cycles_i | input | CNT_W | NOP cycles before the first MRS |
| mrsc_cycles_i | input | CNT_W | Edges between MRS commands, and from the last MRS to the first REFRESH |
| rc_cycles_i | input | CNT_W | Edges between REFRESH commands, and from the last REFRESH to done |
| relock_cycles_i | input | CNT_W | Length of the READ block after a restart pulse |
| mode_word_i | input | ADDR_W | Value for the real mode-register write |
| clk_restart_i | input | 1 | Single-cycle pulse: the clock was stopped and has just restarted |
| req_valid_i | input | 1 | Normal-path request present |
| req_cmd_i | input | 3 | Request command code |
| req_bank_i | input | BANK_W | Request bank |
| req_addr_i | input | ADDR_W | Request address |
| cmd_o | output | 3 | Registered command to the memory |
| bank_o | output | BANK_W | Registered bank to the memory |
| addr_o | output | ADDR_W | Registered address to the memory |
| init_done_o | output | 1 | Start-up complete (sticky) |

## Verification
The bench compares the bus against a schedule it computes for every edge of the start-up. A wrong internal state therefore shows up on the first edge where it matters:
- A wrong interval count moves an MRS or REFRESH off its computed edge.
- A miscounted write index puts the mode word on the wrong MRS.
- A bank counter that skips or repeats puts the wrong bank on a REFRESH.

A state machine that leaves start-up too early shows a request on the bus, or done, while the schedule still expects NOP. A relock state that is lost or not re-armed lets a READ through within one cycle of the edge where the bench expects NOP.

// File: rtl/lldram_init_pkg.sv
package lldram_init_pkg;

    // Command codes on the memory bus
    localparam logic [2:0] CMD_NOP   = 3'd0;
    localparam logic [2:0] CMD_MRS   = 3'd1;
    localparam logic [2:0] CMD_REF   = 3'd2;
    localparam logic [2:0] CMD_READ  = 3'd3;
    localparam logic [2:0] CMD_WRITE = 3'd4;

    typedef enum logic [2:0] {
        ST_BOOT_WAIT = 3'd0,
        ST_MRS_GAP   = 3'd1,
        ST_REF_GAP   = 3'd2,
        ST_READY     = 3'd3,
        ST_RELOCK    = 3'd4
    } seq_state_e;

endpackage

// File: rtl/lldram_gap_timer.sv
// Elapsed-cycle timer shared by every wait of the sequencer.
module lldram_gap_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr_i) begin
            cnt_d = '0;
        end else if (cnt_q == {CNT_W{1'b1}}) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
        // The wait ends in the cycle whose edge completes limit_i edges
        // (a limit of zero acts as one).
        expire_o = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/lldram_mrs_addr.sv
// Builds the address for a mode-register write.
module lldram_mrs_addr #(
    parameter int ADDR_W   = 20,
    parameter int FORCE_LO = 10,
    parameter int FORCE_HI = 17
) (
    input  logic [ADDR_W-1:0] mode_word_i,
    input  logic              is_real_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] keep_mask;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
        if (i >= FORCE_LO && i <= FORCE_HI) begin : g_zero
            assign keep_mask[i] = 1'b0;
        end else begin : g_keep
            assign keep_mask[i] = 1'b1;
        end
    end

    // Dummy writes drive an all-zero address; the real one drives the
    // mode word with the forced window cleared.
    assign addr_o = is_real_i ? (mode_word_i & keep_mask) : '0;
endmodule

// File: rtl/lldram_req_gate.sv
// Passes normal-path requests once start-up is over, holding back READ
// while the clock relocks.
module lldram_req_gate
    import lldram_init_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int ADDR_W = 20
) (
    input  logic              pass_i,
    input  logic              hold_read_i,
    input  logic              valid_i,
    input  logic [2:0]        cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [2:0]        cmd_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic blocked;

    always_comb begin
        blocked = hold_read_i && (cmd_i == CMD_READ);
        if (pass_i && valid_i && !blocked) begin
            cmd_o  = cmd_i;
            bank_o = bank_i;
            addr_o = addr_i;
        end else begin
            cmd_o  = CMD_NOP;
            bank_o = '0;
            addr_o = '0;
        end
    end
endmodule

// File: rtl/lldram_init_seq.sv
// Power-up command sequencer for a multi-bank low-latency DRAM.
module lldram_init_seq
    import lldram_init_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int NUM_BANKS = 8,
    parameter int NUM_MRS   = 3,
    parameter int CNT_W     = 16,
    parameter int FORCE_LO  = 10,
    parameter int FORCE_HI  = 17,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  stab_cycles_i,
    input  logic [CNT_W-1:0]  mrsc_cycles_i,
    input  logic [CNT_W-1:0]  rc_cycles_i,
    input  logic [CNT_W-1:0]  relock_cycles_i,
    input  logic [ADDR_W-1:0] mode_word_i,
    input  logic              clk_restart_i,
    input  logic              req_valid_i,
    input  logic [2:0]        req_cmd_i,
    input  logic [BANK_W-1:0] req_bank_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic [2:0]        cmd_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              init_done_o
);
    localparam int MRS_CW = $clog2(NUM_MRS + 1);
    localparam int REF_CW = $clog2(NUM_BANKS + 1);
    localparam logic [MRS_CW-1:0] MRS_LAST  = MRS_CW'(NUM_MRS - 1);
    localparam logic [MRS_CW-1:0] MRS_TOTAL = MRS_CW'(NUM_MRS);
    localparam logic [REF_CW-1:0] REF_TOTAL = REF_CW'(NUM_BANKS);

    typedef struct packed {
        seq_state_e         state;
        logic [MRS_CW-1:0]  mrs_cnt;
        logic [REF_CW-1:0]  ref_cnt;
        logic               done;
        logic [2:0]         cmd;
        logic [BANK_W-1:0]  bank;
        logic [ADDR_W-1:0]  addr;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    logic              tmr_clr;
    logic              tmr_expire;
    logic [CNT_W-1:0]  tmr_limit;
    logic [ADDR_W-1:0] mrs_addr;
    logic              gate_pass;
    logic              gate_hold_read;
    logic [2:0]        gate_cmd;
    logic [BANK_W-1:0] gate_bank;
    logic [ADDR_W-1:0] gate_addr;

    lldram_gap_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (tmr_clr),
        .limit_i  (tmr_limit),
        .expire_o (tmr_expire)
    );

    lldram_mrs_addr #(
        .ADDR_W   (ADDR_W),
        .FORCE_LO (FORCE_LO),
        .FORCE_HI (FORCE_HI)
    ) u_mrs_addr (
        .mode_word_i (mode_word_i),
        .is_real_i   (seq_q.mrs_cnt == MRS_LAST),
        .addr_o      (mrs_addr)
    );

    assign gate_pass      = (seq_q.state == ST_READY) || (seq_q.state == ST_RELOCK);
    assign gate_hold_read = (seq_q.state == ST_RELOCK) || clk_restart_i;

    lldram_req_gate #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_gate (
        .pass_i      (gate_pass),
        .hold_read_i (gate_hold_read),
        .valid_i     (req_valid_i),
        .cmd_i       (req_cmd_i),
        .bank_i      (req_bank_i),
        .addr_i      (req_addr_i),
        .cmd_o       (gate_cmd),
        .bank_o      (gate_bank),
        .addr_o      (gate_addr)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.cmd  = CMD_NOP;
        seq_d.bank = '0;
        seq_d.addr = '0;
        tmr_clr    = 1'b0;
        tmr_limit  = stab_cycles_i;

        unique case (seq_q.state)
            ST_BOOT_WAIT: begin
                tmr_limit = stab_cycles_i;
                if (tmr_expire) begin
                    tmr_clr       = 1'b1;
                    seq_d.cmd     = CMD_MRS;
                    seq_d.addr    = mrs_addr;
                    seq_d.mrs_cnt = seq_q.mrs_cnt + 1'b1;
                    seq_d.state   = ST_MRS_GAP;
                end
            end
            ST_MRS_GAP: begin
                tmr_limit = mrsc_cycles_i;
                if (tmr_expire) begin
                    tmr_clr = 1'b1;
                    if (seq_q.mrs_cnt == MRS_TOTAL) begin
                        seq_d.cmd     = CMD_REF;
                        seq_d.bank    = '0;
                        seq_d.ref_cnt = REF_CW'(1);
                        seq_d.state   = ST_REF_GAP;
                    end else begin
                        seq_d.cmd     = CMD_MRS;
                        seq_d.addr    = mrs_addr;
                        seq_d.mrs_cnt = seq_q.mrs_cnt + 1'b1;
                    end
                end
            end
            ST_REF_GAP: begin
                tmr_limit = rc_cycles_i;
                if (tmr_expire) begin
                    tmr_clr = 1'b1;
                    if (seq_q.ref_cnt == REF_TOTAL) begin
                        seq_d.done  = 1'b1;
                        seq_d.state = ST_READY;
                    end else begin
                        seq_d.cmd     = CMD_REF;
                        seq_d.bank    = seq_q.ref_cnt[BANK_W-1:0];
                        seq_d.ref_cnt = seq_q.ref_cnt + 1'b1;
                    end
                end
            end
            ST_READY: begin
                tmr_limit  = relock_cycles_i;
                seq_d.cmd  = gate_cmd;
                seq_d.bank = gate_bank;
                seq_d.addr = gate_addr;
                if (clk_restart_i) begin
                    tmr_clr     = 1'b1;
                    seq_d.state = ST_RELOCK;
                end
            end
            ST_RELOCK: begin
                tmr_limit  = relock_cycles_i;
                seq_d.cmd  = gate_cmd;
                seq_d.bank = gate_bank;
                seq_d.addr = gate_addr;
                if (clk_restart_i) begin
                    tmr_clr = 1'b1;
                end else if (tmr_expire) begin
                    tmr_clr     = 1'b1;
                    seq_d.state = ST_READY;
                end
            end
            default: begin
                seq_d.state = ST_BOOT_WAIT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state   <= ST_BOOT_WAIT;
            seq_q.mrs_cnt <= '0;
            seq_q.ref_cnt <= '0;
            seq_q.done    <= 1'b0;
            seq_q.cmd     <= CMD_NOP;
            seq_q.bank    <= '0;
            seq_q.addr    <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cmd_o       = seq_q.cmd;
    assign bank_o      = seq_q.bank;
    assign addr_o      = seq_q.addr;
    assign init_done_o = seq_q.done;
endmodule

// File: rtl/lldram_init_seq_chk.sv
module lldram_init_seq_chk
    import lldram_init_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int FORCE_LO = 10,
    parameter int FORCE_HI = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_restart_i,
    input logic              req_valid_i,
    input logic [2:0]        cmd_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              init_done_o
);
    // R7: before done only start-up commands reach the bus
    a_r7_init_cmds_only: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done_o |-> (cmd_o == CMD_NOP || cmd_o == CMD_MRS || cmd_o == CMD_REF));

    // R6: done is sticky
    a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_o |=> init_done_o);

    // R4: forced address window is low on every start-up MRS
    a_r4_mrs_window_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_done_o && cmd_o == CMD_MRS) |-> (addr_o[FORCE_HI:FORCE_LO] == '0));

    // R5: start-up refreshes carry a zero address
    a_r5_ref_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_done_o && cmd_o == CMD_REF) |-> (addr_o == '0));

    // R9: a restart pulse keeps READ off the next bus cycle
    a_r9_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done_o && clk_restart_i) |=> (cmd_o != CMD_READ));

    // R8: no request after start-up gives NOP
    a_r8_idle_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done_o && !req_valid_i) |=> (cmd_o == CMD_NOP));
endmodule

bind lldram_init_seq lldram_init_seq_chk #(
    .ADDR_W   (ADDR_W),
    .FORCE_LO (FORCE_LO),
    .FORCE_HI (FORCE_HI)
) u_chk (.*);

// File: tb/tb_lldram_init_seq.sv
`timescale 1ns/1ps
module tb_lldram_init_seq;
    localparam int ADDR_W = 20;
    localparam int BANK_W = 3;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CNT_W-1:0]  stab_cycles_i = '0;
    logic [CNT_W-1:0]  mrsc_cycles_i = '0;
    logic [CNT_W-1:0]  rc_cycles_i = '0;
    logic [CNT_W-1:0]  relock_cycles_i = '0;
    logic [ADDR_W-1:0] mode_word_i = '0;
    logic              clk_restart_i = 1'b0;
    logic              req_valid_i = 1'b0;
    logic [2:0]        req_cmd_i = '0;
    logic [BANK_W-1:0] req_bank_i = '0;
    logic [ADDR_W-1:0] req_addr_i = '0;
    logic [2:0]        cmd_o;
    logic [BANK_W-1:0] bank_o;
    logic [ADDR_W-1:0] addr_o;
    logic              init_done_o;

    lldram_init_seq dut (.*);

    always #4 clk = ~clk;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    typedef struct packed {
        logic [15:0] stab;
        logic [15:0] mrsc;
        logic [15:0] rc;
        logic [15:0] relock;
        logic [19:0] mode;
    } row_t;

    localparam row_t ROWS [5] = '{
        '{16'd5,  16'd3, 16'd4, 16'd6, 20'hFFFFF},
        '{16'd1,  16'd1, 16'd1, 16'd1, 20'h003FF},
        '{16'd0,  16'd0, 16'd0, 16'd0, 20'hA5C3E},
        '{16'd12, 16'd2, 16'd5, 16'd3, 20'h40155},
        '{16'd3,  16'd7, 16'd2, 16'd9, 20'hC0C00}
    };

    localparam logic [19:0] KEEP = ~(20'hFF << 10);

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_bus(input string req, input logic [2:0] c,
                           input logic [BANK_W-1:0] b, input logic [ADDR_W-1:0] a);
        chk(req, "cmd", 32'(cmd_o), 32'(c));
        chk(req, "bank", 32'(bank_o), 32'(b));
        chk(req, "addr", 32'(addr_o), 32'(a));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // Table walk: full start-up per row, READ requests held throughout (R7)
        for (int r = 0; r < 5; r++) begin
            int s, m, c, t_done;
            s = (ROWS[r].stab == 0) ? 1 : int'(ROWS[r].stab);
            m = (ROWS[r].mrsc == 0) ? 1 : int'(ROWS[r].mrsc);
            c = (ROWS[r].rc   == 0) ? 1 : int'(ROWS[r].rc);
            t_done = s + 3 * m + 8 * c;
            stab_cycles_i   = ROWS[r].stab;
            mrsc_cycles_i   = ROWS[r].mrsc;
            rc_cycles_i     = ROWS[r].rc;
            relock_cycles_i = ROWS[r].relock;
            mode_word_i     = ROWS[r].mode;
            req_valid_i     = 1'b1;
            req_cmd_i       = 3'd3;
            req_bank_i      = 3'd3;
            req_addr_i      = 20'h5A5A5;
            rst_n = 1'b0;
            tick();
            // R1 reset state
            chk_bus("R1", 3'd0, '0, '0);
            chk("R1", "done", 32'(init_done_o), 32'd0);
            rst_n = 1'b1;
            for (int k = 1; k <= t_done; k++) begin
                logic [2:0]        ec;
                logic [BANK_W-1:0] eb;
                logic [ADDR_W-1:0] ea;
                string             tag;
                ec = 3'd0; eb = '0; ea = '0;
                tag = (k < s) ? "R2" : "R7";
                for (int i = 0; i < 3; i++) begin
                    if (k == s + i * m) begin
                        ec  = 3'd1;
                        ea  = (i == 2) ? (ROWS[r].mode & KEEP) : '0;
                        tag = (i == 0) ? "R2" : ((i == 2) ? "R4" : "R3");
                    end
                end
                for (int b = 0; b < 8; b++) begin
                    if (k == s + 3 * m + b * c) begin
                        ec  = 3'd2;
                        eb  = BANK_W'(b);
                        tag = "R5";
                    end
                end
                tick();
                chk_bus(tag, ec, eb, ea);
                chk("R6", "done", 32'(init_done_o), (k >= t_done) ? 32'd1 : 32'd0);
            end
            req_valid_i = 1'b0;
        end

        // R8: pass-through after done, one-edge latency
        relock_cycles_i = 16'd4;
        req_valid_i = 1'b1; req_cmd_i = 3'd4; req_bank_i = 3'd5; req_addr_i = 20'h12345;
        tick();
        chk_bus("R8", 3'd4, 3'd5, 20'h12345);
        req_valid_i = 1'b0;
        tick();
        chk_bus("R8", 3'd0, '0, '0);

        // R9: READ held for the pulse cycle plus relock cycles
        req_valid_i = 1'b1; req_cmd_i = 3'd3; req_bank_i = 3'd2; req_addr_i = 20'h00777;
        clk_restart_i = 1'b1;
        tick();
        clk_restart_i = 1'b0;
        chk_bus("R9", 3'd0, '0, '0);
        for (int j = 0; j < 4; j++) begin
            tick();
            chk_bus("R9", 3'd0, '0, '0);
            chk("R6", "done", 32'(init_done_o), 32'd1);
        end
        tick();
        chk_bus("R9", 3'd3, 3'd2, 20'h00777);

        // R9: non-READ passes in the window, READ still held
        req_cmd_i = 3'd4;
        clk_restart_i = 1'b1;
        tick();
        clk_restart_i = 1'b0;
        chk_bus("R9", 3'd4, 3'd2, 20'h00777);
        req_cmd_i = 3'd3;
        for (int j = 0; j < 4; j++) begin
            tick();
            chk_bus("R9", 3'd0, '0, '0);
        end
        tick();
        chk_bus("R9", 3'd3, 3'd2, 20'h00777);

        // R10: second pulse inside the window restarts the wait
        clk_restart_i = 1'b1;
        tick();
        clk_restart_i = 1'b0;
        chk_bus("R10", 3'd0, '0, '0);
        tick();
        chk_bus("R10", 3'd0, '0, '0);
        tick();
        chk_bus("R10", 3'd0, '0, '0);
        clk_restart_i = 1'b1;
        tick();
        clk_restart_i = 1'b0;
        chk_bus("R10", 3'd0, '0, '0);
        for (int j = 0; j < 4; j++) begin
            tick();
            chk_bus("R10", 3'd0, '0, '0);
        end
        tick();
        chk_bus("R10", 3'd3, 3'd2, 20'h00777);
        req_valid_i = 1'b0;

        // R1: reset in the middle of operation
        rst_n = 1'b0;
        tick();
        chk_bus("R1", 3'd0, '0, '0);
        chk("R1", "done", 32'(init_done_o), 32'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule